// File: doc/BRIEF.md
# Powered-Port Disconnect Timer

This block watches each powered port of a power-sourcing controller and decides when the attached powered device has gone away. An upstream comparator reports, per port, whether the port current is under the minimum holding level (around 7.5 mA). The block turns that flag into a per-port timer. The timer advances only while the port is powered, the disconnect function is enabled and the undercurrent flag is present. Any cycle with enough current sends the timer back to zero.

If the timer reaches the disconnect interval, the block raises a power-off request for that port. It also emits a one-cycle disconnect event, which a fault-event register elsewhere can capture. The request stays up until the port reports that it is unpowered. Two enable inputs exist per port: the DC enable and a legacy AC enable. Either one arms the same DC mechanism. With both cleared, a powered port is never shut off by this block. The interval, in clock cycles, and the port count are parameters. Every port has its own timer.

Top module: `dcdisc_monitor`

## Requirements
- R1: During and right after reset, all `off_req` and `disc_evt` bits are 0.
- R2: When a port is powered and enabled and `under_cur` stays high for DISC_CYCLES consecutive clock edges, `off_req` for that port is 1 after the last of those edges.
- R3: A single cycle with `under_cur` low restarts the count from zero. DISC_CYCLES-1 low-current edges, then one recovered edge, then DISC_CYCLES-1 more low-current edges produce no request. A port that gets minimum current at least once per interval stays on.
- R4: `off_req` stays 1 while `port_on` stays 1. It returns to 0 at the first edge where `port_on` is sampled 0.
- R5: With both `dc_en` and `ac_en` at 0 for a port, that port never raises `off_req` or `disc_evt`, however long the undercurrent lasts.
- R6: `ac_en` alone (with `dc_en` at 0) gives the same DC disconnect timing as `dc_en`.
- R7: While `port_on` is 0 the timer is held at zero. Counting begins from zero at the first powered edge.
- R8: Ports are independent. Stimulus on one port never changes another port's outputs.
- R9: `disc_evt` is high for exactly one cycle per expiry, in the same cycle that `off_req` first rises. It does not repeat while the request is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_on | input | NUM_PORTS | Port is currently powered |
| under_cur | input | NUM_PORTS | Port current below the minimum holding level |
| dc_en | input | NUM_PORTS | DC disconnect enable |
| ac_en | input | NUM_PORTS | Legacy AC disconnect enable, mapped onto the DC mechanism |
| off_req | output | NUM_PORTS | Request to remove power from the port |
| disc_evt | output | NUM_PORTS | One-cycle disconnect fault event |

## Verification
The bound checker tests several per-port rules on every cycle. A request may only rise after a powered, enabled undercurrent cycle. An event always comes with a request and never lasts two cycles. An unpowered port clears its request. A disabled port, or one whose current has just recovered, produces no event. Timing properties need the reference model and the directed scenarios: the exact expiry cycle, the full restart after a one-cycle recovery, the identical timing under the legacy enable, and the isolation between ports.

// File: rtl/dcdisc_pkg.sv
package dcdisc_pkg;

    // Per-port conditioned inputs handed to a timer lane.
    typedef struct packed {
        logic powered;
        logic low_cur;
        logic armed;
    } port_sense_t;

endpackage

// File: rtl/dcdisc_enable_merge.sv
module dcdisc_enable_merge #(
    parameter int NUM_PORTS = 4
) (
    input  logic [NUM_PORTS-1:0] dc_en,
    input  logic [NUM_PORTS-1:0] ac_en,
    output logic [NUM_PORTS-1:0] armed
);
    // The legacy AC enable has no circuit of its own; it arms the DC path.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_merge
        assign armed[p] = dc_en[p] | ac_en[p];
    end
endmodule

// File: rtl/dcdisc_port_timer.sv
module dcdisc_port_timer
    import dcdisc_pkg::*;
#(
    parameter int DISC_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  port_sense_t sense,
    output logic        off_req,
    output logic        disc_evt
);
    localparam int CW = $clog2(DISC_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DISC_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          off;
        logic          evt;
    } lane_t;

    lane_t s_d, s_q;
    logic  qual;

    always_comb begin
        s_d     = s_q;
        s_d.evt = 1'b0;
        qual    = sense.powered & sense.armed & sense.low_cur & ~s_q.off;
        if (qual) begin
            if (s_q.cnt == LAST) begin
                s_d.cnt = '0;
                s_d.off = 1'b1;
                s_d.evt = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else begin
            s_d.cnt = '0;
        end
        if (!sense.powered) begin
            s_d.off = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign off_req  = s_q.off;
    assign disc_evt = s_q.evt;
endmodule

// File: rtl/dcdisc_monitor.sv
module dcdisc_monitor
    import dcdisc_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int DISC_CYCLES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] port_on,
    input  logic [NUM_PORTS-1:0] under_cur,
    input  logic [NUM_PORTS-1:0] dc_en,
    input  logic [NUM_PORTS-1:0] ac_en,
    output logic [NUM_PORTS-1:0] off_req,
    output logic [NUM_PORTS-1:0] disc_evt
);
    logic [NUM_PORTS-1:0] armed;

    dcdisc_enable_merge #(.NUM_PORTS(NUM_PORTS)) merge_i (
        .dc_en (dc_en),
        .ac_en (ac_en),
        .armed (armed)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
        port_sense_t sense;
        assign sense.powered = port_on[p];
        assign sense.low_cur = under_cur[p];
        assign sense.armed   = armed[p];

        dcdisc_port_timer #(.DISC_CYCLES(DISC_CYCLES)) timer_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .sense    (sense),
            .off_req  (off_req[p]),
            .disc_evt (disc_evt[p])
        );
    end
endmodule

// File: rtl/dcdisc_monitor_chk.sv
module dcdisc_monitor_chk #(
    parameter int NUM_PORTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PORTS-1:0] port_on,
    input logic [NUM_PORTS-1:0] under_cur,
    input logic [NUM_PORTS-1:0] dc_en,
    input logic [NUM_PORTS-1:0] ac_en,
    input logic [NUM_PORTS-1:0] off_req,
    input logic [NUM_PORTS-1:0] disc_evt
);
    logic started;
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        // R2
        rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || !started)
            $rose(off_req[p]) |-> ($past(port_on[p]) && $past(under_cur[p])
                                   && ($past(dc_en[p]) || $past(ac_en[p]))));
        // R4
        unpowered_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !port_on[p] |=> !off_req[p]);
        // R5
        disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!dc_en[p] && !ac_en[p]) |=> !disc_evt[p]);
        // R3
        recovered_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !under_cur[p] |=> !disc_evt[p]);
        // R9
        evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            disc_evt[p] |=> !disc_evt[p]);
        // R9
        evt_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            disc_evt[p] |-> off_req[p]);
    end
endmodule

bind dcdisc_monitor dcdisc_monitor_chk #(.NUM_PORTS(NUM_PORTS)) chk_i (.*);

// File: tb/dcdisc_monitor_tb_top.sv
module dcdisc_monitor_tb_top;
    localparam int N = 4;
    localparam int D = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] port_on = '0, under_cur = '0, dc_en = '0, ac_en = '0;
    logic [N-1:0] off_req, disc_evt;

    int checks = 0;
    int fails  = 0;
    string phase = "R1";
    bit done = 1'b0;

    always #2 clk = ~clk;

    dcdisc_monitor #(.NUM_PORTS(N), .DISC_CYCLES(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .port_on(port_on), .under_cur(under_cur),
        .dc_en(dc_en), .ac_en(ac_en), .off_req(off_req), .disc_evt(disc_evt)
    );

    // Behavioural reference: low-current run length, pending request, event.
    int run  [N];
    bit mreq [N];
    bit mevt [N];

    always @(posedge clk) begin
        for (int p = 0; p < N; p++) begin
            if (!rst_n) begin
                run[p] = 0; mreq[p] = 0; mevt[p] = 0;
            end else begin
                mevt[p] = 0;
                if (port_on[p] && (dc_en[p] || ac_en[p]) && under_cur[p] && !mreq[p]) begin
                    run[p] = run[p] + 1;
                    if (run[p] >= D) begin
                        mreq[p] = 1; mevt[p] = 1; run[p] = 0;
                    end
                end else begin
                    run[p] = 0;
                end
                if (!port_on[p]) mreq[p] = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            for (int p = 0; p < N; p++) begin
                checks++;
                if (off_req[p] !== mreq[p] || disc_evt[p] !== mevt[p]) begin
                    fails++;
                    $display("FAIL %s port %0d: off_req/disc_evt actual %b%b expected %b%b",
                             phase, p, off_req[p], disc_evt[p], mreq[p], mevt[p]);
                end
            end
        end
    end

    task automatic expect_port(input int p, input bit req, input bit evt, input string tag);
        checks++;
        if (off_req[p] !== req || disc_evt[p] !== evt) begin
            fails++;
            $display("FAIL %s port %0d: actual %b%b expected %b%b", tag, p,
                     off_req[p], disc_evt[p], req, evt);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        fails++; checks++;
        $display("FAIL watchdog expired in %s", phase);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1
        wait_n(3);
        for (int p = 0; p < N; p++) expect_port(p, 0, 0, "R1 in reset");
        rst_n = 1'b1;
        wait_n(1);
        for (int p = 0; p < N; p++) expect_port(p, 0, 0, "R1 after reset");

        // R7: undercurrent on an unpowered port does nothing
        phase = "R7";
        dc_en = '1; under_cur[0] = 1'b1;
        wait_n(2 * D);
        expect_port(0, 0, 0, "R7 unpowered");
        port_on[0] = 1'b1;
        wait_n(D - 1);
        expect_port(0, 0, 0, "R7 one edge short");
        // R2 / R9
        phase = "R2";
        wait_n(1);
        expect_port(0, 1, 1, "R2 expiry");
        phase = "R9";
        wait_n(1);
        expect_port(0, 1, 0, "R9 single event");
        wait_n(2 * D);
        expect_port(0, 1, 0, "R9 no repeat");
        // R4
        phase = "R4";
        port_on[0] = 1'b0;
        wait_n(1);
        expect_port(0, 0, 0, "R4 request cleared");
        under_cur[0] = 1'b0;
        wait_n(2);

        // R3: one recovered cycle restarts the count
        phase = "R3";
        port_on[0] = 1'b1; under_cur[0] = 1'b1;
        wait_n(D - 1);
        under_cur[0] = 1'b0;
        wait_n(1);
        under_cur[0] = 1'b1;
        wait_n(D - 1);
        expect_port(0, 0, 0, "R3 restart");
        for (int k = 0; k < 4; k++) begin
            under_cur[0] = 1'b0; wait_n(1);
            under_cur[0] = 1'b1; wait_n(D - 1);
        end
        expect_port(0, 0, 0, "R3 periodic current");
        wait_n(1);
        expect_port(0, 1, 1, "R3 full interval");
        port_on[0] = 1'b0; under_cur[0] = 1'b0;
        wait_n(2);

        // R5: both enables cleared
        phase = "R5";
        dc_en = '0; ac_en = '0;
        port_on[1] = 1'b1; under_cur[1] = 1'b1;
        wait_n(4 * D);
        expect_port(1, 0, 0, "R5 disabled");

        // R6: legacy enable alone
        phase = "R6";
        ac_en[1] = 1'b1;
        wait_n(D - 1);
        expect_port(1, 0, 0, "R6 before expiry");
        wait_n(1);
        expect_port(1, 1, 1, "R6 expiry");
        port_on[1] = 1'b0; under_cur[1] = 1'b0; ac_en = '0;
        wait_n(2);

        // R8: independent ports, staggered starts
        phase = "R8";
        dc_en = '1; port_on = '1;
        under_cur[2] = 1'b1;
        wait_n(3);
        under_cur[3] = 1'b1;
        wait_n(D - 3);
        expect_port(2, 1, 1, "R8 port2 expiry");
        expect_port(3, 0, 0, "R8 port3 still counting");
        expect_port(1, 0, 0, "R8 port1 untouched");
        wait_n(3);
        expect_port(3, 1, 1, "R8 port3 expiry");
        expect_port(2, 1, 0, "R8 port2 held");
        port_on = '0; under_cur = '0;
        wait_n(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule